// File: doc/BRIEF.md
# Two-Wire Bus Transaction Sequencer

This block performs whole two-wire bus transactions on its own by driving the register interface of a byte-level bus controller that sits beside it. A command supplies a 7-bit chip address, zero to four offset bytes packed into one word, a byte count and a kind: write, read, or presence probe. Write payload is pulled from a valid/ready byte stream. Received bytes leave on a valid-qualified byte port.

For each bus step the sequencer writes the controller's control register, and for byte sends also its data register. It then polls the controller's interrupt flag, with a bounded poll budget. After the flag rises it waits a short settle time before it samples the status code and compares it with the code the step should produce. The first failure ends the useful part of the transaction and is packed into a 32-bit diagnostic word. A STOP is then always issued, and the sequencer waits for the bus to report idle. A single-cycle completion pulse carries the final word, which is zero on success.

Top module: `xfer_sequencer`

## Requirements
- R1: After each START or byte step the sequencer waits for the flag (control bit 3), waits SETTLE_CYCLES more cycles, and only then samples status. If the status differs from the expected code, the transaction fails with class 0x01.
- R2: If the flag is not seen within POLL_LIMIT polls of TICK_CYCLES cycles each, the step fails with class 0x02.
- R3: The error word holds the class in bits 31:24, the control value seen at completion in 23:16, the status seen in 15:8 and the expected status in 7:0. Only the first error is kept.
- R4: The address byte is the chip address shifted left by one, with bit 0 set to 1 for reading. It expects status 0x40 when reading and 0x18 when writing.
- R5: Offset bytes are sent highest index first, and each expects 0x28. Write payload bytes follow in stream order, each also expecting 0x28.
- R6: A read that has offset bytes first sends the address with bit 0 clear and the offsets. It then issues a repeated START, with no STOP in between, which expects 0x10. Every first START expects 0x08.
- R7: Each received byte except the last is acknowledged (control bit 2 set), expecting 0x50. The last byte is not acknowledged, expecting 0x58. Read bytes appear on the read port in order.
- R8: A STOP is issued at the end of every transaction, including after a failure, and the sequencer waits for status 0xF8. A STOP timeout (class 0x02, expected 0xF8) is reported only when no earlier error occurred.
- R9: A probe (kind 2 or 3) sends the address for reading and receives one byte without acknowledge. The byte is not output, and a zero word means the chip answered.
- R10: Control writes use enable bit 6, START bit 5, STOP bit 4 and ACK bit 2, and always write the flag bit 3 as 0 to clear it. The register select is 0 for control and 1 for data.
- R11: `cmd_ready` is high only while idle. `done` is a one-cycle pulse, and `err_word` holds the result until the next completion; reset clears it to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command accepted |
| cmd_kind | input | 2 | 0 write, 1 read, 2/3 probe |
| cmd_chip | input | 7 | Chip address |
| cmd_off | input | 8*OFF_BYTES | Offset bytes, byte i in bits 8i+7:8i |
| cmd_olen | input | OLEN_W | Number of offset bytes (clamped to OFF_BYTES) |
| cmd_len | input | LEN_W | Payload byte count |
| wr_valid | input | 1 | Write payload byte available |
| wr_data | input | 8 | Write payload byte |
| wr_ready | output | 1 | Payload byte consumed this cycle |
| rd_valid | output | 1 | Received byte valid |
| rd_data | output | 8 | Received byte |
| done | output | 1 | Transaction finished (one cycle) |
| err_word | output | 32 | Zero on success, else packed error |
| reg_we | output | 1 | Controller register write strobe |
| reg_sel | output | 1 | 0 control register, 1 data register |
| reg_wdata | output | 8 | Register write value |
| reg_ctrl | input | 8 | Controller control register readback |
| reg_stat | input | 8 | Controller status code |
| reg_rdata | input | 8 | Controller received data |

## Verification
The bench builds the sequencer with POLL_LIMIT 12, TICK_CYCLES 2 and SETTLE_CYCLES 3. With these values a hung step or STOP times out after 24 cycles, so timeouts at the START, offset and STOP stages all fit in a short run. The controller model raises its status two cycles after the flag, so a sequencer that skips the settle time samples a stale code. An absent chip address makes the model answer with non-acknowledge codes, which exercises the wrong-status path and the STOP-priority rule.

// File: rtl/xseq_pkg.sv
package xseq_pkg;

  // control register bit positions decoded by the bus controller
  localparam int CTL_ACK   = 2;
  localparam int CTL_FLAG  = 3;
  localparam int CTL_STOP  = 4;
  localparam int CTL_START = 5;
  localparam int CTL_EN    = 6;

  // status codes produced by the bus controller
  localparam logic [7:0] SC_START  = 8'h08;
  localparam logic [7:0] SC_RSTART = 8'h10;
  localparam logic [7:0] SC_AW_ACK = 8'h18;
  localparam logic [7:0] SC_DW_ACK = 8'h28;
  localparam logic [7:0] SC_AR_ACK = 8'h40;
  localparam logic [7:0] SC_DR_ACK = 8'h50;
  localparam logic [7:0] SC_DR_NAK = 8'h58;
  localparam logic [7:0] SC_IDLE   = 8'hF8;

  localparam logic [7:0] CLS_NONE    = 8'h00;
  localparam logic [7:0] CLS_STATUS  = 8'h01;
  localparam logic [7:0] CLS_TIMEOUT = 8'h02;

  localparam logic SEL_CTRL = 1'b0;
  localparam logic SEL_DATA = 1'b1;

  typedef enum logic [2:0] {
    STEP_START, STEP_ADDRW, STEP_OFF, STEP_WDATA,
    STEP_RSTART, STEP_ADDRR, STEP_RX
  } step_e;

  typedef enum logic [2:0] {
    ACT_ADDRW, ACT_ADDRR, ACT_OFF, ACT_WDATA, ACT_RSTART, ACT_RX, ACT_STOP
  } act_e;

endpackage

// File: rtl/xseq_step_wait.sv
module xseq_step_wait
  import xseq_pkg::*;
#(
  parameter int POLL_LIMIT    = 1000,
  parameter int TICK_CYCLES   = 4,
  parameter int SETTLE_CYCLES = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       idle_mode_i,
  input  logic [7:0] expect_i,
  input  logic [7:0] ctrl_i,
  input  logic [7:0] stat_i,
  output logic       done_o,
  output logic [7:0] cls_o,
  output logic [7:0] lctrl_o,
  output logic [7:0] lstat_o
);

  localparam int PW = $clog2(POLL_LIMIT + 1);
  localparam int TW = $clog2(TICK_CYCLES + 1);
  localparam int SW = $clog2(SETTLE_CYCLES + 1);

  typedef enum logic [1:0] {W_IDLE, W_POLL, W_SETTLE} wst_e;

  wst_e        st_q, st_n;
  logic [PW-1:0] poll_q, poll_n;
  logic [TW-1:0] tick_q, tick_n;
  logic [SW-1:0] set_q, set_n;
  logic        mode_q, mode_n;
  logic        done_q, done_n;
  logic [7:0]  cls_q, cls_n, lctrl_q, lctrl_n, lstat_q, lstat_n;

  always_comb begin
    st_n    = st_q;
    poll_n  = poll_q;
    tick_n  = tick_q;
    set_n   = set_q;
    mode_n  = mode_q;
    done_n  = 1'b0;
    cls_n   = cls_q;
    lctrl_n = lctrl_q;
    lstat_n = lstat_q;
    if (start_i) begin
      st_n   = W_POLL;
      poll_n = '0;
      tick_n = '0;
      set_n  = '0;
      mode_n = idle_mode_i;
    end else begin
      case (st_q)
        W_POLL: begin
          if (mode_q ? (stat_i == SC_IDLE) : ctrl_i[CTL_FLAG]) begin
            if (mode_q) begin
              st_n = W_IDLE; done_n = 1'b1; cls_n = CLS_NONE;
              lctrl_n = ctrl_i; lstat_n = stat_i;
            end else begin
              st_n = W_SETTLE; set_n = '0;
            end
          end else if (tick_q == TW'(TICK_CYCLES - 1)) begin
            tick_n = '0;
            if (poll_q == PW'(POLL_LIMIT - 1)) begin
              st_n = W_IDLE; done_n = 1'b1; cls_n = CLS_TIMEOUT;
              lctrl_n = ctrl_i; lstat_n = stat_i;
            end else begin
              poll_n = poll_q + 1'b1;
            end
          end else begin
            tick_n = tick_q + 1'b1;
          end
        end
        W_SETTLE: begin
          if (set_q == SW'(SETTLE_CYCLES - 1)) begin
            st_n = W_IDLE; done_n = 1'b1;
            cls_n = (stat_i == expect_i) ? CLS_NONE : CLS_STATUS;
            lctrl_n = ctrl_i; lstat_n = stat_i;
          end else begin
            set_n = set_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= W_IDLE; poll_q <= '0; tick_q <= '0; set_q <= '0;
      mode_q <= 1'b0; done_q <= 1'b0; cls_q <= '0; lctrl_q <= '0; lstat_q <= '0;
    end else begin
      st_q <= st_n; poll_q <= poll_n; tick_q <= tick_n; set_q <= set_n;
      mode_q <= mode_n; done_q <= done_n; cls_q <= cls_n;
      lctrl_q <= lctrl_n; lstat_q <= lstat_n;
    end
  end

  assign done_o  = done_q;
  assign cls_o   = cls_q;
  assign lctrl_o = lctrl_q;
  assign lstat_o = lstat_q;

  a_r2_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
    poll_q < PW'(POLL_LIMIT));

  a_r1_settle_before_compare: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !mode_q && cls_q != CLS_TIMEOUT) |-> $past(st_q == W_SETTLE));

endmodule

// File: rtl/xseq_err_pack.sv
module xseq_err_pack (
  input  logic [7:0]  cls_i,
  input  logic [7:0]  lctrl_i,
  input  logic [7:0]  lstat_i,
  input  logic [7:0]  expect_i,
  output logic [31:0] word_o
);
  // R3 field order: class, control, status, expected
  assign word_o = {cls_i, lctrl_i, lstat_i, expect_i};
endmodule

// File: rtl/xfer_sequencer.sv
module xfer_sequencer
  import xseq_pkg::*;
#(
  parameter int OFF_BYTES     = 4,
  parameter int LEN_W         = 8,
  parameter int POLL_LIMIT    = 1000,
  parameter int TICK_CYCLES   = 4,
  parameter int SETTLE_CYCLES = 3,
  localparam int OLEN_W       = $clog2(OFF_BYTES + 1),
  localparam int OFF_W        = 8 * OFF_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_kind,
  input  logic [6:0]        cmd_chip,
  input  logic [OFF_W-1:0]  cmd_off,
  input  logic [OLEN_W-1:0] cmd_olen,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic              wr_valid,
  input  logic [7:0]        wr_data,
  output logic              wr_ready,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic              done,
  output logic [31:0]       err_word,
  output logic              reg_we,
  output logic              reg_sel,
  output logic [7:0]        reg_wdata,
  input  logic [7:0]        reg_ctrl,
  input  logic [7:0]        reg_stat,
  input  logic [7:0]        reg_rdata
);

  typedef enum logic [2:0] {
    S_IDLE, S_CSTART, S_WDATA, S_WCTRL, S_RXCTRL, S_WAIT, S_STOP, S_SWAIT
  } st_e;

  localparam logic [7:0] CV_EN    = 8'(1 << CTL_EN);
  localparam logic [7:0] CV_START = CV_EN | 8'(1 << CTL_START);
  localparam logic [7:0] CV_STOP  = CV_EN | 8'(1 << CTL_STOP);
  localparam logic [7:0] CV_ACK   = CV_EN | 8'(1 << CTL_ACK);

  st_e               st_q, st_n;
  step_e             step_q, step_n;
  logic              rd_q, rd_n, pr_q, pr_n;
  logic [6:0]        chip_q, chip_n;
  logic [OFF_W-1:0]  off_q, off_n;
  logic [OLEN_W-1:0] oleft_q, oleft_n;
  logic [LEN_W-1:0]  left_q, left_n;
  logic [31:0]       err_q, err_n, res_q, res_n;
  logic [7:0]        exp_q, exp_n, byte_q, byte_n;
  logic              src_q, src_n, ack_q, ack_n;
  logic              done_q, done_n, rdv_q, rdv_n;
  logic [7:0]        rdd_q, rdd_n;

  logic              w_start, w_idle, w_done;
  logic [7:0]        w_cls, w_lctrl, w_lstat, pk_exp;
  logic [31:0]       pk_word;

  // offset byte lanes, selected by remaining count (highest index first)
  logic [7:0] off_lane [OFF_BYTES];
  for (genvar g = 0; g < OFF_BYTES; g++) begin : g_lane
    assign off_lane[g] = off_q[8*g +: 8];
  end
  logic [7:0] off_byte;
  always_comb begin
    off_byte = 8'h00;
    for (int i = 0; i < OFF_BYTES; i++)
      if (oleft_q == OLEN_W'(i + 1)) off_byte = off_lane[i];
  end

  xseq_step_wait #(
    .POLL_LIMIT(POLL_LIMIT), .TICK_CYCLES(TICK_CYCLES), .SETTLE_CYCLES(SETTLE_CYCLES)
  ) i_wait (
    .clk(clk), .rst_n(rst_n), .start_i(w_start), .idle_mode_i(w_idle),
    .expect_i(exp_q), .ctrl_i(reg_ctrl), .stat_i(reg_stat),
    .done_o(w_done), .cls_o(w_cls), .lctrl_o(w_lctrl), .lstat_o(w_lstat)
  );

  assign pk_exp = (st_q == S_SWAIT) ? SC_IDLE : exp_q;

  xseq_err_pack i_pack (
    .cls_i(w_cls), .lctrl_i(w_lctrl), .lstat_i(w_lstat), .expect_i(pk_exp),
    .word_o(pk_word)
  );

  always_comb begin
    act_e act;
    st_n = st_q; step_n = step_q; rd_n = rd_q; pr_n = pr_q; chip_n = chip_q;
    off_n = off_q; oleft_n = oleft_q; left_n = left_q; err_n = err_q; res_n = res_q;
    exp_n = exp_q; byte_n = byte_q; src_n = src_q; ack_n = ack_q;
    done_n = 1'b0; rdv_n = 1'b0; rdd_n = rdd_q;
    reg_we = 1'b0; reg_sel = SEL_CTRL; reg_wdata = 8'h00;
    w_start = 1'b0; w_idle = 1'b0; wr_ready = 1'b0;
    act = ACT_STOP;
    case (st_q)
      S_IDLE: if (cmd_valid) begin
        rd_n    = (cmd_kind == 2'd1);
        pr_n    = cmd_kind[1];
        chip_n  = cmd_chip;
        off_n   = cmd_off;
        oleft_n = cmd_kind[1] ? '0 :
                  (cmd_olen > OLEN_W'(OFF_BYTES) ? OLEN_W'(OFF_BYTES) : cmd_olen);
        left_n  = cmd_kind[1] ? LEN_W'(1) : cmd_len;
        err_n   = '0;
        exp_n   = SC_START;
        step_n  = STEP_START;
        st_n    = S_CSTART;
      end
      S_CSTART: begin
        reg_we = 1'b1; reg_wdata = CV_START; w_start = 1'b1; st_n = S_WAIT;
      end
      S_WDATA: if (!src_q || wr_valid) begin
        reg_we = 1'b1; reg_sel = SEL_DATA;
        reg_wdata = src_q ? wr_data : byte_q;
        wr_ready = src_q;
        st_n = S_WCTRL;
      end
      S_WCTRL: begin
        reg_we = 1'b1; reg_wdata = CV_EN; w_start = 1'b1; st_n = S_WAIT;
      end
      S_RXCTRL: begin
        reg_we = 1'b1; reg_wdata = ack_q ? CV_ACK : CV_EN; w_start = 1'b1; st_n = S_WAIT;
      end
      S_WAIT: if (w_done) begin
        if (w_cls != CLS_NONE) begin
          err_n = pk_word;
          st_n  = S_STOP;
        end else begin
          case (step_q)
            STEP_START:  act = (pr_q || (rd_q && oleft_q == '0)) ? ACT_ADDRR : ACT_ADDRW;
            STEP_ADDRW, STEP_OFF, STEP_WDATA:
              if (oleft_q != '0)             act = ACT_OFF;
              else if (rd_q)                 act = ACT_RSTART;
              else if (left_q != '0)         act = ACT_WDATA;
              else                           act = ACT_STOP;
            STEP_RSTART: act = ACT_ADDRR;
            default:     act = (left_q != '0) ? ACT_RX : ACT_STOP;
          endcase
          if (step_q == STEP_RX && !pr_q) begin
            rdv_n = 1'b1;
            rdd_n = reg_rdata;
          end
          src_n = 1'b0;
          case (act)
            ACT_ADDRW: begin
              byte_n = {chip_q, 1'b0}; exp_n = SC_AW_ACK; step_n = STEP_ADDRW; st_n = S_WDATA;
            end
            ACT_ADDRR: begin
              byte_n = {chip_q, 1'b1}; exp_n = SC_AR_ACK; step_n = STEP_ADDRR; st_n = S_WDATA;
            end
            ACT_OFF: begin
              byte_n = off_byte; oleft_n = oleft_q - 1'b1;
              exp_n = SC_DW_ACK; step_n = STEP_OFF; st_n = S_WDATA;
            end
            ACT_WDATA: begin
              src_n = 1'b1; left_n = left_q - 1'b1;
              exp_n = SC_DW_ACK; step_n = STEP_WDATA; st_n = S_WDATA;
            end
            ACT_RSTART: begin
              exp_n = SC_RSTART; step_n = STEP_RSTART; st_n = S_CSTART;
            end
            ACT_RX: begin
              ack_n = (left_q > LEN_W'(1)); left_n = left_q - 1'b1;
              exp_n = (left_q > LEN_W'(1)) ? SC_DR_ACK : SC_DR_NAK;
              step_n = STEP_RX; st_n = S_RXCTRL;
            end
            default: st_n = S_STOP;
          endcase
        end
      end
      S_STOP: begin
        reg_we = 1'b1; reg_wdata = CV_STOP; w_start = 1'b1; w_idle = 1'b1; st_n = S_SWAIT;
      end
      S_SWAIT: if (w_done) begin
        done_n = 1'b1;
        res_n  = (err_q == '0 && w_cls != CLS_NONE) ? pk_word : err_q;
        st_n   = S_IDLE;
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; step_q <= STEP_START; rd_q <= 1'b0; pr_q <= 1'b0; chip_q <= '0;
      off_q <= '0; oleft_q <= '0; left_q <= '0; err_q <= '0; res_q <= '0;
      exp_q <= '0; byte_q <= '0; src_q <= 1'b0; ack_q <= 1'b0;
      done_q <= 1'b0; rdv_q <= 1'b0; rdd_q <= '0;
    end else begin
      st_q <= st_n; step_q <= step_n; rd_q <= rd_n; pr_q <= pr_n; chip_q <= chip_n;
      off_q <= off_n; oleft_q <= oleft_n; left_q <= left_n; err_q <= err_n; res_q <= res_n;
      exp_q <= exp_n; byte_q <= byte_n; src_q <= src_n; ack_q <= ack_n;
      done_q <= done_n; rdv_q <= rdv_n; rdd_q <= rdd_n;
    end
  end

  assign cmd_ready = (st_q == S_IDLE);
  assign done      = done_q;
  assign err_word  = res_q;
  assign rd_valid  = rdv_q;
  assign rd_data   = rdd_q;

  a_r8_stop_before_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(st_q == S_SWAIT));

  a_r3_first_error_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != S_IDLE && err_q != '0) |=> (err_q == $past(err_q)));

  a_r7_last_byte_nak: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == SEL_CTRL && st_q == S_RXCTRL && left_q == '0)
      |-> !reg_wdata[CTL_ACK]);

  a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

endmodule

// File: tb/test_xfer_sequencer.sv
module test_xfer_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 3;
  localparam int LAG = 2;
  localparam logic [6:0] ABSENT = 7'h55;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic cmd_valid = 1'b0, cmd_ready;
  logic [1:0] cmd_kind = '0;
  logic [6:0] cmd_chip = '0;
  logic [31:0] cmd_off = '0;
  logic [2:0] cmd_olen = '0;
  logic [7:0] cmd_len = '0;
  logic wr_valid = 1'b1, wr_ready;
  logic [7:0] wr_data;
  logic rd_valid, done, reg_we, reg_sel;
  logic [7:0] rd_data, reg_wdata;
  logic [31:0] err_word;
  logic [7:0] m_ctrl, m_stat, m_rdata;

  xfer_sequencer #(.OFF_BYTES(4), .LEN_W(8), .POLL_LIMIT(12), .TICK_CYCLES(2),
                   .SETTLE_CYCLES(3)) i_xfer_sequencer (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_kind(cmd_kind), .cmd_chip(cmd_chip), .cmd_off(cmd_off), .cmd_olen(cmd_olen),
    .cmd_len(cmd_len), .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .err_word(err_word),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_ctrl(m_ctrl), .reg_stat(m_stat), .reg_rdata(m_rdata)
  );

  // controller model
  logic mclr = 1'b0;
  int hang_step = 0;
  logic hang_stop = 1'b0;
  int m_cnt, m_step, m_rx_n, log_n, m_stops, rd_n, wr_idx;
  logic m_fl, m_busy, m_first, m_dwr;
  logic [7:0] m_nst, m_data;
  logic [7:0] log_b [0:15];
  logic [7:0] rd_buf [0:15];

  assign wr_data = 8'hD0 + 8'(wr_idx);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl <= 8'h00; m_stat <= 8'hF8; m_rdata <= 8'h00; m_cnt <= 0; m_step <= 0;
      m_rx_n <= 0; log_n <= 0; m_stops <= 0; rd_n <= 0; wr_idx <= 0;
      m_fl <= 1'b0; m_busy <= 1'b0; m_first <= 1'b0; m_dwr <= 1'b0; m_nst <= 8'h00; m_data <= 8'h00;
    end else if (mclr) begin
      m_step <= 0; m_rx_n <= 0; log_n <= 0; m_stops <= 0; rd_n <= 0; wr_idx <= 0;
    end else begin
      if (m_cnt != 0) begin
        m_cnt <= m_cnt - 1;
        if (m_cnt == LAG + 1 && m_fl) m_ctrl[3] <= 1'b1;
        if (m_cnt == 1) m_stat <= m_nst;
      end
      if (rd_valid) begin rd_buf[rd_n] <= rd_data; rd_n <= rd_n + 1; end
      if (wr_ready) wr_idx <= wr_idx + 1;
      if (reg_we && reg_sel) begin
        m_data <= reg_wdata; m_dwr <= 1'b1;
        log_b[log_n] <= reg_wdata; log_n <= log_n + 1;
      end
      if (reg_we && !reg_sel) begin
        m_ctrl <= reg_wdata; m_step <= m_step + 1; m_dwr <= 1'b0;
        if (reg_wdata[4]) begin
          m_stops <= m_stops + 1; m_busy <= 1'b0; m_fl <= 1'b0; m_nst <= 8'hF8;
          m_cnt <= hang_stop ? 0 : LAT + LAG;
        end else if (m_step + 1 == hang_step) begin
          m_cnt <= 0;
        end else begin
          m_cnt <= LAT + LAG; m_fl <= 1'b1;
          if (reg_wdata[5]) begin
            m_nst <= m_busy ? 8'h10 : 8'h08; m_busy <= 1'b1; m_first <= 1'b1;
          end else if (m_dwr) begin
            if (m_first) begin
              m_first <= 1'b0;
              if (m_data[0]) m_nst <= (m_data[7:1] == ABSENT) ? 8'h48 : 8'h40;
              else           m_nst <= (m_data[7:1] == ABSENT) ? 8'h20 : 8'h18;
            end else m_nst <= 8'h28;
          end else begin
            m_nst <= reg_wdata[2] ? 8'h50 : 8'h58;
            m_rdata <= 8'hB0 + 8'(m_rx_n); m_rx_n <= m_rx_n + 1;
          end
        end
      end
    end
  end

  int n_chk = 0, n_fail = 0;
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [31:0] got;
  task automatic run(input logic [1:0] k, input logic [6:0] c, input logic [31:0] o,
                     input logic [2:0] ol, input logic [7:0] l);
    int wd;
    @(negedge clk) mclr = 1'b1;
    @(negedge clk) mclr = 1'b0;
    cmd_valid = 1'b1; cmd_kind = k; cmd_chip = c; cmd_off = o; cmd_olen = ol; cmd_len = l;
    @(negedge clk) cmd_valid = 1'b0;
    wd = 0;
    while (!done && wd < 3000) begin @(negedge clk); wd++; end
    if (wd >= 3000) chk("watchdog R11", 32'd0, 32'd1);
    got = err_word;
    @(negedge clk);
  endtask

  typedef struct packed {
    logic [1:0] kind; logic [6:0] chip; logic [31:0] off;
    logic [2:0] olen; logic [7:0] len; logic [31:0] err;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'd0, 7'h50, 32'h0000A1B2, 3'd2, 8'd3, 32'h0},          // R5 write with offsets
    '{2'd0, 7'h21, 32'h0,        3'd0, 8'd1, 32'h0},          // R4 plain write
    '{2'd1, 7'h50, 32'h0,        3'd0, 8'd2, 32'h0},          // R6 R7 read, no offset
    '{2'd1, 7'h50, 32'h11223344, 3'd4, 8'd1, 32'h0},          // R6 combined read
    '{2'd2, 7'h50, 32'h0,        3'd0, 8'd0, 32'h0},          // R9 probe present
    '{2'd2, 7'h55, 32'h0,        3'd0, 8'd0, 32'h01484840},   // R9 R1 probe absent
    '{2'd0, 7'h55, 32'h000000EE, 3'd1, 8'd2, 32'h01482018},   // R1 R3 write nak
    '{2'd1, 7'h1C, 32'h0,        3'd0, 8'd0, 32'h0}           // R6 read of zero bytes
  };

  initial begin
    int wdg;
    wdg = 0;
    repeat (3) @(negedge clk);
    chk("R11 reset ready", {31'd0, cmd_ready}, 32'd1);
    chk("R11 reset done", {31'd0, done}, 32'd0);
    chk("R11 reset err", err_word, 32'd0);
    chk("R10 reset no write", {31'd0, reg_we}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < 8; v++) begin
      logic [7:0] eb [0:15];
      int en;
      vec_t t;
      t = VECS[v];
      run(t.kind, t.chip, t.off, t.olen, t.len);
      chk($sformatf("R3 vec%0d err word", v), got, t.err);
      chk($sformatf("R8 vec%0d one stop", v), 32'(m_stops), 32'd1);
      en = 0;
      if (t.kind == 2'd0 || (t.kind == 2'd1 && t.olen != 0)) begin
        eb[en] = {t.chip, 1'b0}; en++;
        for (int i = int'(t.olen) - 1; i >= 0; i--) begin eb[en] = t.off[8*i +: 8]; en++; end
      end
      if (t.kind != 2'd0) begin eb[en] = {t.chip, 1'b1}; en++; end
      else for (int i = 0; i < int'(t.len); i++) begin eb[en] = 8'hD0 + 8'(i); en++; end
      if (t.err == 0) begin
        chk($sformatf("R5 vec%0d bus byte count", v), 32'(log_n), 32'(en));
        for (int i = 0; i < en; i++)
          chk($sformatf("R4 R5 vec%0d bus byte %0d", v, i), {24'd0, log_b[i]}, {24'd0, eb[i]});
        if (t.kind == 2'd1) begin
          chk($sformatf("R7 vec%0d read count", v), 32'(rd_n), 32'(t.len));
          for (int i = 0; i < int'(t.len); i++)
            chk($sformatf("R7 vec%0d read byte %0d", v, i), {24'd0, rd_buf[i]}, {24'd0, 8'hB0 + 8'(i)});
        end else chk($sformatf("R9 vec%0d no read out", v), 32'(rd_n), 32'd0);
      end else chk($sformatf("R1 vec%0d stopped after addr", v), 32'(log_n), 32'd1);
    end

    // R2 R10: START never answered
    hang_step = 1;
    run(2'd0, 7'h50, 32'h0, 3'd0, 8'd1);
    chk("R2 R10 start timeout word", got, 32'h0260F808);
    chk("R8 stop after timeout", 32'(m_stops), 32'd1);
    // R2: offset byte step never answered
    hang_step = 3;
    run(2'd0, 7'h50, 32'h77, 3'd1, 8'd0);
    chk("R2 offset timeout word", got, 32'h024018_28);
    hang_step = 0;
    // R8 R10: stop timeout with no earlier error
    hang_stop = 1'b1;
    run(2'd0, 7'h21, 32'h0, 3'd0, 8'd1);
    chk("R8 R10 stop timeout word", got, 32'h025028F8);
    // R8: earlier error wins over stop timeout
    run(2'd2, 7'h55, 32'h0, 3'd0, 8'd0);
    chk("R8 first error priority", got, 32'h01484840);
    hang_stop = 1'b0;
    // R11: result held until next completion
    repeat (5) @(negedge clk);
    chk("R11 result held", err_word, 32'h01484840);
    chk("R11 done is a pulse", {31'd0, done}, 32'd0);
    run(2'd2, 7'h50, 32'h0, 3'd0, 8'd0);
    chk("R9 probe after recovery", got, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog R11 actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
    $finish;
  end

endmodule